// File: doc/BRIEF.md
# Temperature Limit Alert Controller

This block watches a stream of temperature conversion results and compares each one against a programmable upper and lower limit. Each limit has its own hysteresis band. For each side it keeps a level status bit that follows the temperature with hysteresis. It also keeps a read-to-clear crossing flag, which fires once per excursion and re-arms only after the temperature has come back past the hysteresis threshold.

It also collects three event flags from neighbouring logic: new data, a failed CRC check on a bus write, and a slew-rate event. It publishes all of them as one 16-bit status word and drives an active-low alert pin. The pin takes its sources either from the enabled flags (interrupt mode) or, for the high, low and slew sources, from their status levels (comparator mode).

The conversion interface is a valid-only strobe. A result is accepted in every cycle that `conv_valid` is high, and no back-pressure exists, so the producer never waits. Configuration words are plain inputs that are read whenever a conversion is evaluated. Reads of the status and result registers arrive as single-cycle strobes from the bus logic.

Top module: `temp_alert_ctrl`

## Requirements
- R1: Each limit word holds a 14-bit two's-complement temperature in bits 15:2, and bits 1:0 are ignored. The hysteresis word holds the high-side band in bits 15:8 and the low-side band in bits 7:0. Each band is an unsigned count worth 16 temperature LSBs per step.
- R2: On a conversion with valid limits, the high status bit sets when the temperature is strictly greater than the high limit. It clears when the temperature is strictly below (high limit − high band). Otherwise it holds.
- R3: On a conversion with valid limits, the low status bit sets when the temperature is strictly below the low limit. It clears when the temperature is strictly above (low limit + low band). Otherwise it holds.
- R4: A high (low) flag sets on a conversion beyond its limit only while that side's status bit is still clear. It therefore cannot fire again until the status has been released past the hysteresis threshold. A status read clears the flag, and a set in the same cycle wins over the clear.
- R5: When the high limit is less than or equal to the low limit (signed), conversions leave both status bits and both crossing flags unchanged.
- R6: The data-ready flag sets on every accepted conversion. It clears on a status read or a result read, and a set in the same cycle wins.
- R7: The CRC flag sets on a `crc_err` pulse and the slew flag sets on a `slew_event` pulse. Both clear on a status read, and a set in the same cycle wins.
- R8: Status word bits 7 down to 0 are: CRC flag, slew level, slew flag, high status, low status, high flag, low flag, data-ready flag. Bits 15:8 are 0. The word shows the current state in the same cycle.
- R9: With `comp_mode`=0, `alert_n` is low whenever any flag has its enable set. Enable bit 0 gates data-ready, bit 1 the low flag, bit 2 the high flag, bit 3 the slew flag and bit 4 the CRC flag.
- R10: With `comp_mode`=1, the low, high and slew enables gate the low status, the high status and the slew level. Data-ready and CRC still use their flags.
- R11: Once `alert_n` has been low, it can return high only in the cycle after a status read or an accepted conversion. Dropping an enable or changing mode does not release it on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_valid | input | 1 | New conversion result strobe |
| conv_temp | input | 14 | Conversion result, two's complement |
| low_limit_word | input | 16 | Low limit register image |
| high_limit_word | input | 16 | High limit register image |
| hyst_word | input | 16 | Hysteresis register image |
| alert_en | input | 5 | Per-source alert enables |
| comp_mode | input | 1 | 0 interrupt mode, 1 comparator mode |
| status_rd | input | 1 | Status register read strobe |
| result_rd | input | 1 | Result register read strobe |
| crc_err | input | 1 | CRC failure event pulse |
| slew_event | input | 1 | Slew limit crossing event pulse |
| slew_level | input | 1 | Current slew-over-limit level |
| status_word | output | 16 | Status register image |
| alert_n | output | 1 | Active-low alert |

## Verification
The bench drives temperatures into the dead band between each limit and its hysteresis threshold. A design that compared against the limit alone, or re-armed a flag without the release, would drop status or fire the flag twice there. It swaps the limits so that high is equal to low, to catch logic that keeps evaluating against an inverted window. It also puts a read and a new event in the same cycle, which exposes a clear-wins priority that loses an event. Finally, it removes an enable under an active alert, so a pin that releases at once instead of waiting for a read or conversion shows up as a mismatch.

// File: rtl/tla_pkg.sv
package tla_pkg;
  localparam int NSRC = 5;
  // alert source / enable indices
  localparam int SRC_DRDY = 0;
  localparam int SRC_LOW  = 1;
  localparam int SRC_HIGH = 2;
  localparam int SRC_SLEW = 3;
  localparam int SRC_CRC  = 4;
  // sources that switch to a level in comparator mode
  localparam logic [NSRC-1:0] LEVEL_CAPABLE = 5'b01110;
  // status word positions
  localparam int ST_DRDY  = 0;
  localparam int ST_LFLAG = 1;
  localparam int ST_HFLAG = 2;
  localparam int ST_LSTAT = 3;
  localparam int ST_HSTAT = 4;
  localparam int ST_SFLAG = 5;
  localparam int ST_SLVL  = 6;
  localparam int ST_CRC   = 7;
endpackage

// File: rtl/tla_limit_channel.sv
module tla_limit_channel #(
  parameter int TW = 14,
  parameter int HW = 8,
  parameter bit IS_HIGH = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_valid,
  input  logic          limits_ok,
  input  logic [TW-1:0] temp,
  input  logic [TW-1:0] limit,
  input  logic [HW-1:0] hyst,
  input  logic          rd_clr,
  output logic          stat,
  output logic          flag
);
  localparam int EW  = TW + HW;
  localparam int PAD = EW - HW - 4;

  logic signed [EW-1:0] t_e, l_e, h_e, thr;
  logic beyond, back, eval;

  assign t_e  = {{HW{temp[TW-1]}}, temp};
  assign l_e  = {{HW{limit[TW-1]}}, limit};
  assign h_e  = {{PAD{1'b0}}, hyst, 4'b0000};
  assign eval = conv_valid && limits_ok;

  generate
    if (IS_HIGH) begin : g_high
      assign thr    = l_e - h_e;
      assign beyond = t_e > l_e;
      assign back   = t_e < thr;
    end else begin : g_low
      assign thr    = l_e + h_e;
      assign beyond = t_e < l_e;
      assign back   = t_e > thr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (eval && beyond)    stat <= 1'b1;
      else if (eval && back) stat <= 1'b0;
      if (eval && beyond && !stat) flag <= 1'b1;
      else if (rd_clr)             flag <= 1'b0;
    end
  end

  // flag may only rise together with an asserted status level
  assert_flag_needs_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> stat);
  // status changes only on an evaluated conversion
  assert_status_only_on_conv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(eval) && $past(rst_n)) |-> $stable(stat));
endmodule

// File: rtl/tla_event_flags.sv
module tla_event_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_valid,
  input  logic status_rd,
  input  logic result_rd,
  input  logic crc_err,
  input  logic slew_event,
  output logic drdy,
  output logic crc_flag,
  output logic slew_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drdy      <= 1'b0;
      crc_flag  <= 1'b0;
      slew_flag <= 1'b0;
    end else begin
      if (conv_valid)                  drdy <= 1'b1;
      else if (status_rd || result_rd) drdy <= 1'b0;
      if (crc_err)        crc_flag <= 1'b1;
      else if (status_rd) crc_flag <= 1'b0;
      if (slew_event)     slew_flag <= 1'b1;
      else if (status_rd) slew_flag <= 1'b0;
    end
  end

  assert_drdy_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |=> drdy);
  assert_rd_clears_crc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !crc_err) |=> !crc_flag);
endmodule

// File: rtl/tla_alert_drive.sv
module tla_alert_drive
  import tla_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            comp_mode,
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] levels,
  input  logic [NSRC-1:0] enables,
  input  logic            release_ev,
  output logic            alert_n
);
  logic [NSRC-1:0] src;
  logic raw, hold;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (LEVEL_CAPABLE[i]) begin : g_lvl
        assign src[i] = comp_mode ? levels[i] : flags[i];
      end else begin : g_flg
        assign src[i] = flags[i];
      end
    end
  endgenerate

  assign raw = |(src & enables);

  always_ff @(posedge clk) begin
    if (!rst_n)          hold <= 1'b0;
    else if (release_ev) hold <= 1'b0;
    else                 hold <= hold | raw;
  end

  assign alert_n = !(raw || hold);

  assert_sticky_alert_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(alert_n)) |-> $past(release_ev));
endmodule

// File: rtl/temp_alert_ctrl.sv
module temp_alert_ctrl
  import tla_pkg::*;
#(
  parameter int TW = 14,
  parameter int HW = 8,
  parameter int WW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            conv_valid,
  input  logic [TW-1:0]   conv_temp,
  input  logic [WW-1:0]   low_limit_word,
  input  logic [WW-1:0]   high_limit_word,
  input  logic [WW-1:0]   hyst_word,
  input  logic [NSRC-1:0] alert_en,
  input  logic            comp_mode,
  input  logic            status_rd,
  input  logic            result_rd,
  input  logic            crc_err,
  input  logic            slew_event,
  input  logic            slew_level,
  output logic [WW-1:0]   status_word,
  output logic            alert_n
);
  logic [TW-1:0] lo_lim, hi_lim;
  logic limits_ok;
  logic hi_stat, hi_flag, lo_stat, lo_flag;
  logic drdy, crc_flag, slew_flag;
  logic [NSRC-1:0] flags, levels;

  assign lo_lim    = low_limit_word[WW-1:WW-TW];
  assign hi_lim    = high_limit_word[WW-1:WW-TW];
  assign limits_ok = $signed(hi_lim) > $signed(lo_lim);

  tla_limit_channel #(.TW(TW), .HW(HW), .IS_HIGH(1'b1)) u_high (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .limits_ok(limits_ok),
    .temp(conv_temp), .limit(hi_lim), .hyst(hyst_word[2*HW-1:HW]),
    .rd_clr(status_rd), .stat(hi_stat), .flag(hi_flag));

  tla_limit_channel #(.TW(TW), .HW(HW), .IS_HIGH(1'b0)) u_low (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .limits_ok(limits_ok),
    .temp(conv_temp), .limit(lo_lim), .hyst(hyst_word[HW-1:0]),
    .rd_clr(status_rd), .stat(lo_stat), .flag(lo_flag));

  tla_event_flags u_events (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .status_rd(status_rd),
    .result_rd(result_rd), .crc_err(crc_err), .slew_event(slew_event),
    .drdy(drdy), .crc_flag(crc_flag), .slew_flag(slew_flag));

  always_comb begin
    flags = '0;
    flags[SRC_DRDY] = drdy;
    flags[SRC_LOW]  = lo_flag;
    flags[SRC_HIGH] = hi_flag;
    flags[SRC_SLEW] = slew_flag;
    flags[SRC_CRC]  = crc_flag;
    levels = flags;
    levels[SRC_LOW]  = lo_stat;
    levels[SRC_HIGH] = hi_stat;
    levels[SRC_SLEW] = slew_level;
  end

  tla_alert_drive u_alert (
    .clk(clk), .rst_n(rst_n), .comp_mode(comp_mode), .flags(flags),
    .levels(levels), .enables(alert_en), .release_ev(status_rd || conv_valid),
    .alert_n(alert_n));

  always_comb begin
    status_word = '0;
    status_word[ST_DRDY]  = drdy;
    status_word[ST_LFLAG] = lo_flag;
    status_word[ST_HFLAG] = hi_flag;
    status_word[ST_LSTAT] = lo_stat;
    status_word[ST_HSTAT] = hi_stat;
    status_word[ST_SFLAG] = slew_flag;
    status_word[ST_SLVL]  = slew_level;
    status_word[ST_CRC]   = crc_flag;
  end

  assert_limits_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && !limits_ok && !status_rd) |=> ($stable(hi_flag) && $stable(lo_flag)));
endmodule

// File: tb/temp_alert_ctrl_tb_top.sv
`timescale 1ns/1ps
module temp_alert_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_valid = 1'b0;
  logic [13:0] conv_temp = '0;
  logic [15:0] low_limit_word = 16'hF380;
  logic [15:0] high_limit_word = 16'h2A80;
  logic [15:0] hyst_word = 16'h0A0A;
  logic [4:0] alert_en = 5'h16;
  logic comp_mode = 1'b0, status_rd = 1'b0, result_rd = 1'b0;
  logic crc_err = 1'b0, slew_event = 1'b0, slew_level = 1'b0;
  logic [15:0] status_word;
  logic alert_n;

  always #2.5 clk = ~clk;

  temp_alert_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_temp(conv_temp),
    .low_limit_word(low_limit_word), .high_limit_word(high_limit_word),
    .hyst_word(hyst_word), .alert_en(alert_en), .comp_mode(comp_mode),
    .status_rd(status_rd), .result_rd(result_rd), .crc_err(crc_err),
    .slew_event(slew_event), .slew_level(slew_level),
    .status_word(status_word), .alert_n(alert_n));

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  bit m_hs, m_ls, m_hf, m_lf, m_dr, m_crc, m_sf, m_hold;

  function automatic bit m_raw();
    bit r;
    r = (alert_en[0] && m_dr) || (alert_en[4] && m_crc);
    if (comp_mode)
      r = r || (alert_en[1] && m_ls) || (alert_en[2] && m_hs) || (alert_en[3] && slew_level);
    else
      r = r || (alert_en[1] && m_lf) || (alert_en[2] && m_hf) || (alert_en[3] && m_sf);
    return r;
  endfunction

  function automatic logic [15:0] m_word();
    return {8'h00, m_crc, slew_level, m_sf, m_hs, m_ls, m_hf, m_lf, m_dr};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_hs, m_ls, m_hf, m_lf, m_dr, m_crc, m_sf, m_hold} = '0;
    end else begin
      int hi, lo, t, hh, lh;
      bit raw_now, ok, hf_set, lf_set;
      raw_now = m_raw();
      hi = $signed(high_limit_word[15:2]);
      lo = $signed(low_limit_word[15:2]);
      t  = $signed(conv_temp);
      hh = hyst_word[15:8] * 16;
      lh = hyst_word[7:0] * 16;
      ok = hi > lo;
      hf_set = 0; lf_set = 0;
      if (conv_valid && ok) begin
        hf_set = (t > hi) && !m_hs;
        lf_set = (t < lo) && !m_ls;
        if (t > hi) m_hs = 1; else if (t < hi - hh) m_hs = 0;
        if (t < lo) m_ls = 1; else if (t > lo + lh) m_ls = 0;
      end
      if (hf_set) m_hf = 1; else if (status_rd) m_hf = 0;
      if (lf_set) m_lf = 1; else if (status_rd) m_lf = 0;
      if (conv_valid) m_dr = 1; else if (status_rd || result_rd) m_dr = 0;
      if (crc_err) m_crc = 1; else if (status_rd) m_crc = 0;
      if (slew_event) m_sf = 1; else if (status_rd) m_sf = 0;
      if (status_rd || conv_valid) m_hold = 0; else m_hold = m_hold | raw_now;
    end
  end

  task automatic chk(input bit cond, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      logic [15:0] w;
      bit ea;
      w  = m_word();
      ea = !(m_raw() || m_hold);
      chk(status_word[4] == w[4], "R2 high status", status_word, w);
      chk(status_word[3] == w[3], "R3 low status", status_word, w);
      chk(status_word[2:1] == w[2:1], "R4 crossing flags", status_word, w);
      chk(status_word[0] == w[0], "R6 data-ready", status_word, w);
      chk({status_word[7], status_word[5]} == {w[7], w[5]}, "R7 crc/slew flags", status_word, w);
      chk({status_word[15:8], status_word[6]} == {w[15:8], w[6]}, "R8 layout", status_word, w);
      chk(alert_n == ea, comp_mode ? "R10 comparator alert" : "R9 interrupt alert",
          {15'd0, alert_n}, {15'd0, ea});
    end
  end

  task automatic step();
    @(negedge clk);
    conv_valid = 0; status_rd = 0; result_rd = 0; crc_err = 0; slew_event = 0;
  endtask

  task automatic conv(input int t);
    @(negedge clk);
    conv_valid = 1; conv_temp = 14'(t);
    step();
  endtask

  task automatic rd_status();
    @(negedge clk);
    status_rd = 1;
    step();
  endtask

  task automatic at_neg_check(input bit cond, input string req, input logic [15:0] act, input logic [15:0] exp);
    @(negedge clk);
    chk(cond, req, act, exp);
  endtask

  initial begin
    fork
      begin : watchdog
        #500000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    chk(status_word == 16'h0 && alert_n, "R8 reset state", status_word, 16'h0);
    rst_n = 1;
    step();

    conv(0);                      // R6: data ready set, disabled alert
    chk(status_word[0] && alert_n, "R6 drdy set, R9 not enabled", status_word, 16'h0001);
    @(negedge clk); result_rd = 1; step();
    chk(!status_word[0], "R6 result read clears", status_word, 16'h0);

    high_limit_word = 16'h2A83;   // R1: low bits ignored
    conv(2721);
    chk(status_word[4] && status_word[2] && !alert_n, "R1 R2 R9 above high", status_word, 16'h0015);
    conv(2600);                   // dead band: hold
    chk(status_word[4], "R2 hold in band", status_word, 16'h0010);
    rd_status();
    chk(!status_word[2] && alert_n, "R4 read clears flag", status_word, 16'h0010);
    conv(2800);
    chk(!status_word[2], "R4 no re-fire while status", status_word, 16'h0010);
    conv(2500);
    chk(!status_word[4], "R2 release below threshold", status_word, 16'h0);
    conv(2800);
    chk(status_word[2], "R4 re-armed", status_word, 16'h0004);
    rd_status();

    conv(-900); conv(-700);
    chk(status_word[3] && status_word[1], "R3 low hold in band", status_word, 16'h000A);
    conv(-600);
    chk(!status_word[3], "R3 low release", status_word, 16'h0);
    rd_status();

    high_limit_word = low_limit_word; // R5
    conv(3000); conv(-2000);
    chk(status_word[4:1] == 4'b0, "R5 limits ignored", status_word, 16'h0);
    high_limit_word = 16'h2A80;

    comp_mode = 1;                // R10
    conv(2800); rd_status();
    chk(!alert_n && status_word[4], "R10 status drives alert", {15'd0, alert_n}, 16'h0);
    conv(2000);
    chk(alert_n, "R10 release", {15'd0, alert_n}, 16'h1);
    comp_mode = 0; rd_status();

    conv(2800);                   // R11: sticky after enable drop
    @(negedge clk); alert_en = 5'h10;
    repeat (3) step();
    chk(!alert_n, "R11 sticky", {15'd0, alert_n}, 16'h0);
    conv(2000);
    chk(alert_n, "R11 released by conversion", {15'd0, alert_n}, 16'h1);
    alert_en = 5'h16; rd_status();

    @(negedge clk); crc_err = 1; status_rd = 1; conv_valid = 1; step(); // set wins
    chk(status_word[7] && status_word[0], "R7 R6 set wins", status_word, 16'h0081);
    @(negedge clk); slew_event = 1; slew_level = 1; step();
    chk(status_word[5] && status_word[6], "R7 R8 slew", status_word, 16'h0060);
    slew_level = 0; rd_status();

    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      conv_valid = ($urandom % 3) == 0;
      conv_temp  = 14'(int'($urandom % 4600) - 1300);
      status_rd  = ($urandom % 6) == 0;
      result_rd  = ($urandom % 8) == 0;
      crc_err    = ($urandom % 20) == 0;
      slew_event = ($urandom % 15) == 0;
      if (($urandom % 10) == 0) slew_level = ~slew_level;
      if (($urandom % 40) == 0) alert_en = 5'($urandom);
      if (($urandom % 50) == 0) comp_mode = ~comp_mode;
      if (($urandom % 60) == 0) hyst_word = 16'($urandom);
      if (($urandom % 70) == 0) high_limit_word = (($urandom % 3) == 0) ? 16'hE000 : 16'h2A80;
    end
    step();
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule